// File: doc/BRIEF.md
# Input Pulse Interval Capture Timer

This block is one timer channel that measures the time between qualifying transitions on an external input. A free-running up-counter advances by one on every cycle where the count-clock enable is high. When a qualifying transition arrives, or when software fires the start trigger while the channel is already running, the counter value is copied into a capture register. The counter then restarts from zero and a one-cycle interrupt pulse is raised. At each capture, an overflow status bit records whether the counter rolled over since the previous capture.

Software drives single-cycle start and stop strobes. Starting a stopped channel arms it, and the counter is zeroed on the first enabled count clock after that. Stopping freezes the counter and the overflow bit. The edge-select field may be rewritten at any time. The start-interrupt option takes a new value only while the channel is stopped.

No data stream crosses the edge of this block, so there is no valid/ready handshake and no back-pressure. The capture register is a plain readable register. A new capture overwrites it, whether software has read it or not, and the interrupt pulse is the only notice that a capture took place.

Top module: `ivcap_timer`

## Requirements
- R1: While running, with no capture, stop or pending zero-load, the counter increases by one on every cycle with `cnt_tick` high. It wraps from 0xFFFF to 0x0000 and holds on cycles with `cnt_tick` low.
- R2: On a capture event, `cap_data` takes the current count, `cnt_value` becomes 0 and `irq` pulses for exactly one cycle. All three are visible after the clock edge that registers the event.
- R3: At each capture, `ovf` is set to 1 if the counter rolled over since the previous capture, and to 0 otherwise. A rollover in the capture cycle itself counts toward that capture. `ovf` changes at no other time except a start from stopped, which clears it.
- R4: A start strobe while stopped sets `running` after the next edge, and the counter keeps its old value until the first cycle with `cnt_tick` high. That cycle loads 0x0000 instead of incrementing.
- R5: A start strobe while running is a capture event, with the same effects as in R2.
- R6: A stop strobe clears `running` and takes priority over a simultaneous start or edge. While stopped, `cnt_value` and `ovf` hold their values.
- R7: When the start-interrupt option is 1, a start from stopped pulses `irq` once. When it is 0, a start from stopped gives no interrupt.
- R8: `pin_in` passes through two synchronizing flip-flops. The edge-select code is 00 for falling edges, 01 for rising edges, and 10 or 11 for both edges. A qualifying transition is captured on the third rising clock edge after the input changes. Transitions of the other polarity are ignored.
- R9: A mode write while running updates the edge select and leaves the start-interrupt option unchanged. A mode write while stopped updates both.
- R10: While stopped, input transitions cause no capture and no interrupt. After reset, all outputs are 0 and the channel is stopped with edge select 00 and the start-interrupt option 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_tick | input | 1 | Count-clock enable from the prescaler |
| pin_in | input | 1 | Measured input, asynchronous |
| start_trig | input | 1 | Start trigger strobe (one cycle) |
| stop_trig | input | 1 | Stop trigger strobe (one cycle) |
| mode_wr | input | 1 | Mode write strobe |
| mode_edge | input | 2 | Edge select written by `mode_wr` |
| mode_start_irq | input | 1 | Start-interrupt option written by `mode_wr` |
| cap_data | output | 16 | Last captured interval |
| cnt_value | output | 16 | Live counter value |
| running | output | 1 | Enable status |
| ovf | output | 1 | Overflow status from the last capture |
| irq | output | 1 | Capture/start interrupt pulse |

## Verification
A stuck or dropped zero-load after a start shows at `cnt_value` on the first enabled count clock, as a value one above the stale count. A wrap flag that is lost or stale is invisible until the next capture, when `ovf` disagrees. A full 65536-tick interval is needed to expose it, including the case where the rollover and the capture fall in the same cycle. A mode or run state that leaks appears as an `irq` pulse that is missing or extra, three cycles after an input transition or one cycle after a start.

// File: rtl/ivcap_pkg.sv
package ivcap_pkg;

  // Edge qualification code; bit 1 set selects both polarities.
  typedef enum logic [1:0] {
    EDGE_FALL = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_BOTH = 2'b10,
    EDGE_RSVD = 2'b11
  } edge_sel_e;

  function automatic logic edge_match(edge_sel_e sel, logic rise, logic fall);
    case (sel)
      EDGE_FALL: return fall;
      EDGE_RISE: return rise;
      default:   return rise | fall;
    endcase
  endfunction

endpackage

// File: rtl/ivcap_edge_det.sv
module ivcap_edge_det
  import ivcap_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pin_in,
  input  edge_sel_e edge_sel,
  output logic      edge_hit
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   rise;
  logic                   fall;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= pin_in;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_in};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[LAST];
  end

  assign rise     = sync_q[LAST] & ~prev_q;
  assign fall     = ~sync_q[LAST] & prev_q;
  assign edge_hit = edge_match(edge_sel, rise, fall);

endmodule

// File: rtl/ivcap_ctrl.sv
module ivcap_ctrl
  import ivcap_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start_trig,
  input  logic      stop_trig,
  input  logic      mode_wr,
  input  logic [1:0] mode_edge,
  input  logic      mode_start_irq,
  input  logic      edge_hit,
  output edge_sel_e edge_sel,
  output logic      running,
  output logic      arm,
  output logic      halt,
  output logic      cap_evt,
  output logic      irq
);

  logic run_q;
  logic start_irq_q;
  logic irq_q;
  edge_sel_e edge_q;

  // Stop dominates; start from stopped arms; start or edge while running captures.
  assign halt    = run_q & stop_trig;
  assign arm     = ~run_q & start_trig & ~stop_trig;
  assign cap_evt = run_q & ~stop_trig & (start_trig | edge_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
    end else if (halt) begin
      run_q <= 1'b0;
    end else if (arm) begin
      run_q <= 1'b1;
    end
  end

  // Edge select is always writable; the start-interrupt option only while stopped.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_q      <= EDGE_FALL;
      start_irq_q <= 1'b0;
    end else if (mode_wr) begin
      edge_q <= edge_sel_e'(mode_edge);
      if (!run_q) start_irq_q <= mode_start_irq;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= cap_evt | (arm & start_irq_q);
  end

  assign running  = run_q;
  assign edge_sel = edge_q;
  assign irq      = irq_q;

endmodule

// File: rtl/ivcap_counter.sv
module ivcap_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_tick,
  input  logic             running,
  input  logic             arm,
  input  logic             halt,
  input  logic             cap_evt,
  output logic [CNT_W-1:0] cnt_value,
  output logic [CNT_W-1:0] cap_data,
  output logic             ovf,
  output logic             pending
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cap_q;
  logic             ovf_q;
  logic             wrap_q;
  logic             pend_q;
  logic             at_max;
  logic             wrap_now;

  assign at_max   = (cnt_q == CNT_MAX);
  // Rollover that the current cycle would perform, counted toward a capture taken now.
  assign wrap_now = cnt_tick & ~pend_q & at_max;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      cap_q  <= '0;
      ovf_q  <= 1'b0;
      wrap_q <= 1'b0;
      pend_q <= 1'b0;
    end else if (arm) begin
      pend_q <= 1'b1;
      ovf_q  <= 1'b0;
      wrap_q <= 1'b0;
    end else if (halt) begin
      pend_q <= 1'b0;
    end else if (cap_evt) begin
      cap_q  <= pend_q ? '0 : cnt_q;
      ovf_q  <= wrap_q | wrap_now;
      wrap_q <= 1'b0;
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else if (running && cnt_tick) begin
      if (pend_q) begin
        cnt_q  <= '0;
        pend_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + CNT_ONE;
        if (at_max) wrap_q <= 1'b1;
      end
    end
  end

  assign cnt_value = cnt_q;
  assign cap_data  = cap_q;
  assign ovf       = ovf_q;
  assign pending   = pend_q;

endmodule

// File: rtl/ivcap_timer.sv
module ivcap_timer
  import ivcap_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_tick,
  input  logic             pin_in,
  input  logic             start_trig,
  input  logic             stop_trig,
  input  logic             mode_wr,
  input  logic [1:0]       mode_edge,
  input  logic             mode_start_irq,
  output logic [CNT_W-1:0] cap_data,
  output logic [CNT_W-1:0] cnt_value,
  output logic             running,
  output logic             ovf,
  output logic             irq
);

  edge_sel_e edge_sel;
  logic      edge_hit;
  logic      arm;
  logic      halt;
  logic      cap_evt;
  logic      pending;

  ivcap_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_in   (pin_in),
    .edge_sel (edge_sel),
    .edge_hit (edge_hit)
  );

  ivcap_ctrl u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_trig     (start_trig),
    .stop_trig      (stop_trig),
    .mode_wr        (mode_wr),
    .mode_edge      (mode_edge),
    .mode_start_irq (mode_start_irq),
    .edge_hit       (edge_hit),
    .edge_sel       (edge_sel),
    .running        (running),
    .arm            (arm),
    .halt           (halt),
    .cap_evt        (cap_evt),
    .irq            (irq)
  );

  ivcap_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_tick  (cnt_tick),
    .running   (running),
    .arm       (arm),
    .halt      (halt),
    .cap_evt   (cap_evt),
    .cnt_value (cnt_value),
    .cap_data  (cap_data),
    .ovf       (ovf),
    .pending   (pending)
  );

endmodule

// File: rtl/ivcap_timer_chk.sv
module ivcap_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnt_tick,
  input logic             start_trig,
  input logic             stop_trig,
  input logic             cap_evt,
  input logic             pending,
  input logic [CNT_W-1:0] cnt_value,
  input logic             running,
  input logic             ovf,
  input logic             irq
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (running && cnt_tick && !cap_evt && !stop_trig && !pending)
      |=> (cnt_value == $past(cnt_value) + ONE));

  p_capture_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (irq && cnt_value == '0));

  p_ovf_only_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_evt && !start_trig) |=> $stable(ovf));

  p_start_runs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && start_trig && !stop_trig) |=> running);

  p_stop_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stop_trig |=> !running);

  p_stopped_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !start_trig) |=> $stable(cnt_value));

  p_idle_no_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !start_trig) |=> !irq);

endmodule

bind ivcap_timer ivcap_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cnt_tick   (cnt_tick),
  .start_trig (start_trig),
  .stop_trig  (stop_trig),
  .cap_evt    (cap_evt),
  .pending    (pending),
  .cnt_value  (cnt_value),
  .running    (running),
  .ovf        (ovf),
  .irq        (irq)
);

// File: tb/ivcap_timer_tb.sv
module ivcap_timer_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, pin = 1'b0, start_t = 1'b0, stop_t = 1'b0;
  logic        mode_wr = 1'b0, sirq_w = 1'b0;
  logic [1:0]  edge_w = 2'b00;
  logic [15:0] cap_data, cnt_value;
  logic        running, ovf, irq;

  int n_chk = 0, n_err = 0, cycles = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ivcap_timer u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_tick(tick), .pin_in(pin),
    .start_trig(start_t), .stop_trig(stop_t), .mode_wr(mode_wr),
    .mode_edge(edge_w), .mode_start_irq(sirq_w),
    .cap_data(cap_data), .cnt_value(cnt_value), .running(running),
    .ovf(ovf), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Behavioural reference model
  int m_cnt, m_cap, m_edge;
  bit m_s1, m_s2, m_prev, m_run, m_pend, m_wrap, m_ovf, m_irq, m_sirq;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_cap = 0; m_edge = 0;
      m_s1 = 0; m_s2 = 0; m_prev = 0; m_run = 0; m_pend = 0;
      m_wrap = 0; m_ovf = 0; m_irq = 0; m_sirq = 0;
    end else begin
      bit rise, fall, hit, capev, arm, was_run;
      rise = m_s2 && !m_prev;
      fall = !m_s2 && m_prev;
      hit  = (m_edge == 0) ? fall : (m_edge == 1) ? rise : (rise || fall);
      m_prev = m_s2; m_s2 = m_s1; m_s1 = pin;
      capev = m_run && !stop_t && (start_t || hit);
      arm   = !m_run && start_t && !stop_t;
      m_irq = capev || (arm && m_sirq);
      was_run = m_run;
      if (m_run && stop_t) begin
        m_run = 0; m_pend = 0;
      end else if (arm) begin
        m_run = 1; m_pend = 1; m_ovf = 0; m_wrap = 0;
      end else if (capev) begin
        m_cap  = m_pend ? 0 : m_cnt;
        m_ovf  = m_wrap || (tick && !m_pend && m_cnt == 65535);
        m_wrap = 0; m_cnt = 0; m_pend = 0;
      end else if (m_run && tick) begin
        if (m_pend) begin
          m_cnt = 0; m_pend = 0;
        end else if (m_cnt == 65535) begin
          m_cnt = 0; m_wrap = 1;
        end else m_cnt++;
      end
      if (mode_wr) begin
        m_edge = edge_w;
        if (!was_run) m_sirq = sirq_w;
      end
    end
  end

  always @(negedge clk) begin
    if (!done && rst_n) begin
      chk(cnt_value == m_cnt[15:0], "R1 cnt_value", cnt_value, m_cnt);
      chk(cap_data == m_cap[15:0], "R2 cap_data", cap_data, m_cap);
      chk(irq == m_irq, "R2 irq", irq, m_irq);
      chk(ovf == m_ovf, "R3 ovf", ovf, m_ovf);
      chk(running == m_run, "R6 running", running, m_run);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 190000);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_irq(input int n, output int c);
    c = 0;
    repeat (n) begin
      @(negedge clk);
      if (irq) c++;
    end
  endtask

  task automatic pulse_start();
    start_t = 1'b1; @(negedge clk); start_t = 1'b0;
  endtask

  task automatic pulse_stop();
    stop_t = 1'b1; @(negedge clk); stop_t = 1'b0;
  endtask

  task automatic write_mode(input logic [1:0] e, input logic s);
    edge_w = e; sirq_w = s; mode_wr = 1'b1; @(negedge clk); mode_wr = 1'b0;
  endtask

  initial begin
    int c, v, w;
    step(3);
    rst_n = 1'b1;
    step(1);
    // R10 reset state
    chk(cnt_value == 0 && cap_data == 0, "R10 reset data", cnt_value, 0);
    chk(!running && !irq && !ovf, "R10 reset status", {running, irq, ovf}, 0);

    // R10 stopped: edges ignored (falling select by default)
    pin = 1'b1; step(3); pin = 1'b0;
    count_irq(6, c);
    chk(c == 0 && cap_data == 0, "R10 edges while stopped", c, 0);

    write_mode(2'b01, 1'b1);
    pulse_start();
    chk(running == 1'b1, "R4 running after start", running, 1);
    chk(irq == 1'b1, "R7 start interrupt", irq, 1);
    tick = 1'b1;
    step(1);
    chk(cnt_value == 0, "R4 zero load", cnt_value, 0);
    step(5);
    chk(cnt_value == 5, "R1 count steps", cnt_value, 5);

    // R8 latency of a rising edge
    pin = 1'b1;
    step(2);
    chk(irq == 1'b0, "R8 no early capture", irq, 0);
    step(1);
    chk(irq == 1'b1, "R8 capture on third edge", irq, 1);
    chk(cap_data == 7, "R2 captured interval", cap_data, 7);
    chk(cnt_value == 0, "R2 counter cleared", cnt_value, 0);
    pin = 1'b0;
    count_irq(6, c);
    chk(c == 0, "R8 falling ignored under rising select", c, 0);

    // R9 change edge select while running; start-irq write ignored
    write_mode(2'b10, 1'b0);
    w = 0;
    for (int i = 0; i < 4; i++) begin
      pin = ~pin; count_irq(5, c); w += c;
    end
    chk(w == 4, "R8 R9 both edges (10)", w, 4);
    write_mode(2'b11, 1'b0);
    w = 0;
    for (int i = 0; i < 2; i++) begin
      pin = ~pin; count_irq(5, c); w += c;
    end
    chk(w == 2, "R8 reserved code acts as both", w, 2);
    write_mode(2'b00, 1'b0);
    w = 0;
    for (int i = 0; i < 2; i++) begin
      pin = ~pin; count_irq(5, c); w += c;
    end
    chk(w == 1, "R8 falling select", w, 1);

    // R5 software start while running captures
    v = cnt_value;
    pulse_start();
    chk(irq == 1'b1 && cap_data == v, "R5 start capture", cap_data, v);
    chk(cnt_value == 0, "R5 counter cleared", cnt_value, 0);

    // R6 stop freezes; R10 edges ignored
    step(4);
    pulse_stop();
    v = cnt_value;
    chk(running == 1'b0, "R6 stop clears running", running, 0);
    w = 0;
    for (int i = 0; i < 4; i++) begin
      pin = ~pin; count_irq(4, c); w += c;
    end
    chk(cnt_value == v, "R6 counter held", cnt_value, v);
    chk(w == 0, "R10 no interrupt while stopped", w, 0);

    // R9 start-irq option unchanged by running write; R4 stale value until tick
    tick = 1'b0;
    pulse_start();
    chk(irq == 1'b1, "R9 start-irq kept", irq, 1);
    chk(cnt_value == v, "R4 stale until first tick", cnt_value, v);
    tick = 1'b1;
    step(1);
    chk(cnt_value == 0, "R4 first tick loads zero", cnt_value, 0);
    step(1);
    chk(cnt_value == 1, "R1 increment after load", cnt_value, 1);

    // R7 option off
    pulse_stop();
    write_mode(2'b01, 1'b0);
    pulse_start();
    chk(irq == 1'b0, "R7 no start interrupt", irq, 0);

    // R6 stop priority over start
    stop_t = 1'b1; start_t = 1'b1; step(1); stop_t = 1'b0; start_t = 1'b0;
    chk(running == 1'b0 && irq == 1'b0, "R6 stop wins over start", running, 0);
    pulse_start();

    // R3 long interval overflow
    step(2);
    pulse_start();
    step(65540);
    pulse_start();
    chk(ovf == 1'b1, "R3 overflow set", ovf, 1);
    step(10);
    pulse_start();
    chk(ovf == 1'b0, "R3 overflow cleared", ovf, 0);

    // R3 wrap in the capture cycle
    while (cnt_value != 16'hFFFF) @(negedge clk);
    pulse_start();
    chk(ovf == 1'b1 && cap_data == 16'hFFFF, "R3 same-cycle wrap", ovf, 1);

    // R6 ovf held while stopped, R3 cleared on restart
    pulse_stop();
    step(5);
    chk(ovf == 1'b1, "R6 ovf held on stop", ovf, 1);
    pulse_start();
    chk(ovf == 1'b0, "R3 ovf cleared on restart", ovf, 0);
    step(3);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule